// File: doc/BRIEF.md
# Correlated-Error Step-Size Controller

This block tells an LMS adaptive filter when to leave its coarse adaptation step and move to a fine one. The filter hands it one error sign per iteration, together with a valid strobe. The controller tests whether that sign matches the sign of the previous valid error. It counts how many matching adjacent pairs arrive back to back. When that run length reaches a programmable window, the controller moves for good into its steady-state phase. A sign change in the middle of a run clears the count. Short bursts of correlation during convergence therefore never trigger the switch; only a run that is long enough does.

Both step sizes are powers of two, so the filter applies them as an arithmetic right shift. The coarse step is 1/N and the fine step is 2^-p/N, where N is the filter order, a power-of-two parameter, and p is an input. The controller reports the phase and the total shift amount. It is built around a three-state phase machine. PRIME waits for the first valid sign. TRACK counts correlated runs. STEADY holds the fine step. The named transitions are FIRST_SAMPLE (PRIME to TRACK on any valid sample), RUN_GROW and RUN_BREAK (TRACK to itself), and WINDOW_HIT (TRACK to STEADY). STEADY leaves only through reset.

Top module: `scc_top`

## Requirements
- R1: While reset is asserted and after it is released, `steady_sel` is 0 and `mu_shift` equals log2(FILT_ORDER), which is 4 with the default order of 16.
- R2: The first valid sample after reset only records its sign. It cannot count as a matching pair or cause the switch, even when `window_len` is 0.
- R3: Each valid sample whose sign (bit value: 1 negative, 0 non-negative) equals the previous valid sign adds one to the run. The sample that makes the run equal to `window_len` causes the switch.
- R4: A valid sample whose sign differs from the previous valid sign clears the run to zero, so the next run starts counting from one.
- R5: A `window_len` of 0 behaves like 1: the first matching pair switches.
- R6: Once `steady_sel` is 1 it stays 1 until reset, whatever signs, strobes or window values follow.
- R7: Cycles with `err_valid` low change nothing. The run length, the phase and the stored previous sign are all kept.
- R8: `mu_shift` is log2(FILT_ORDER) in the initial phase, and `fine_shift` has no effect there. In the steady phase it is log2(FILT_ORDER) + `fine_shift`, and it follows `fine_shift` combinationally.
- R9: `window_len` is compared live at every matching pair. If it is lowered during a run, the next matching pair switches once the run meets the new value.
- R10: `steady_sel` goes to 1 in the clock cycle after the edge that samples the valid pair completing the window, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Marks an iteration carrying a new error sign |
| err_sign | input | 1 | Sign of the current error, 1 = negative |
| window_len | input | CNT_W | Required run length of matching pairs |
| fine_shift | input | P_W | Extra shift p applied in the steady phase |
| steady_sel | output | 1 | 0 = coarse step, 1 = fine step |
| mu_shift | output | SHIFT_W | Right-shift amount that realises the step size |

## Verification
The bench interleaves a sign change inside a run. A counter missing its clear would switch early, and the break case catches that. An idle cycle carrying the opposite sign sits between two matching samples. A design that loads the previous sign on invalid cycles would break the run and switch late. Window 0, the very first sample after reset, and a window lowered mid-run each expose comparator or priming mistakes through a wrong switch cycle. Changes to `fine_shift` in each phase show whether the shift select is gated by the phase.

// File: rtl/scc_pkg.sv
package scc_pkg;

    typedef enum logic [1:0] {
        ST_PRIME  = 2'd0,
        ST_TRACK  = 2'd1,
        ST_STEADY = 2'd2
    } phase_t;

endpackage

// File: rtl/scc_sign_tracker.sv
module scc_sign_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_valid,
    input  logic sample_sign,
    output logic last_sign,
    output logic signs_agree
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_sign <= 1'b0;
        end else if (sample_valid) begin
            last_sign <= sample_sign;
        end
    end

    always_comb begin
        signs_agree = (sample_sign == last_sign);
    end

endmodule

// File: rtl/scc_run_counter.sv
module scc_run_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] cnt_val
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_val <= '0;
        end else if (cnt_clr) begin
            cnt_val <= '0;
        end else if (cnt_en && (cnt_val != CNT_MAX)) begin
            cnt_val <= cnt_val + 1'b1;
        end
    end

endmodule

// File: rtl/scc_window_cmp.sv
module scc_window_cmp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] win_len,
    output logic             win_reached
);

    logic [CNT_W:0] run_after;

    always_comb begin
        run_after   = {1'b0, cnt_val} + {{CNT_W{1'b0}}, 1'b1};
        win_reached = (run_after >= {1'b0, win_len});
    end

endmodule

// File: rtl/scc_phase_fsm.sv
module scc_phase_fsm
    import scc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sample_valid,
    input  logic   signs_agree,
    input  logic   win_reached,
    output phase_t phase,
    output logic   cnt_en,
    output logic   cnt_clr,
    output logic   steady
);

    phase_t phase_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_PRIME;
        end else begin
            phase <= phase_nx;
        end
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            ST_PRIME: begin
                if (sample_valid) phase_nx = ST_TRACK;
            end
            ST_TRACK: begin
                if (sample_valid && signs_agree && win_reached) phase_nx = ST_STEADY;
            end
            ST_STEADY: begin
                phase_nx = ST_STEADY;
            end
            default: phase_nx = ST_PRIME;
        endcase
    end

    always_comb begin
        cnt_en  = 1'b0;
        cnt_clr = 1'b0;
        steady  = 1'b0;
        unique case (phase)
            ST_PRIME: begin
                cnt_clr = sample_valid;
            end
            ST_TRACK: begin
                cnt_en  = sample_valid && signs_agree;
                cnt_clr = sample_valid && !signs_agree;
            end
            ST_STEADY: begin
                steady = 1'b1;
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/scc_top.sv
module scc_top
    import scc_pkg::*;
#(
    parameter int FILT_ORDER = 16,
    parameter int CNT_W      = 16,
    parameter int P_W        = 4,
    localparam int BASE_SH   = $clog2(FILT_ORDER),
    localparam int MAX_SH    = BASE_SH + (2 ** P_W) - 1,
    localparam int SHIFT_W   = $clog2(MAX_SH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_valid,
    input  logic               err_sign,
    input  logic [CNT_W-1:0]   window_len,
    input  logic [P_W-1:0]     fine_shift,
    output logic               steady_sel,
    output logic [SHIFT_W-1:0] mu_shift
);

    localparam logic [SHIFT_W-1:0] BASE_VAL = SHIFT_W'(BASE_SH);

    logic             prev_sign;
    logic             same_sign;
    logic             reach;
    logic             run_en;
    logic             run_clr;
    logic [CNT_W-1:0] run_count;
    phase_t           phase;

    scc_sign_tracker u_sign (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (err_valid),
        .sample_sign  (err_sign),
        .last_sign    (prev_sign),
        .signs_agree  (same_sign)
    );

    scc_run_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (run_en),
        .cnt_clr (run_clr),
        .cnt_val (run_count)
    );

    scc_window_cmp #(.CNT_W(CNT_W)) u_cmp (
        .cnt_val     (run_count),
        .win_len     (window_len),
        .win_reached (reach)
    );

    scc_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (err_valid),
        .signs_agree  (same_sign),
        .win_reached  (reach),
        .phase        (phase),
        .cnt_en       (run_en),
        .cnt_clr      (run_clr),
        .steady       (steady_sel)
    );

    always_comb begin
        if (steady_sel) begin
            mu_shift = BASE_VAL + SHIFT_W'(fine_shift);
        end else begin
            mu_shift = BASE_VAL;
        end
    end

endmodule

// File: rtl/scc_checker.sv
module scc_checker
    import scc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int P_W     = 4,
    parameter int SHIFT_W = 5,
    parameter int BASE_SH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               err_valid,
    input logic               err_sign,
    input logic [CNT_W-1:0]   window_len,
    input logic [P_W-1:0]     fine_shift,
    input logic               steady_sel,
    input logic [SHIFT_W-1:0] mu_shift,
    input logic [CNT_W-1:0]   run_count,
    input logic               prev_sign,
    input phase_t             phase
);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        steady_sel |=> steady_sel);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> ($stable(steady_sel) && $stable(run_count) && $stable(prev_sign)));

    a_r4_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && (phase == ST_TRACK) && (err_sign != prev_sign)) |=> (run_count == '0));

    a_r10_rise_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(steady_sel) |-> ($past(err_valid) && ($past(err_sign) == $past(prev_sign))));

    a_r3_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(steady_sel) |-> (({1'b0, $past(run_count)} + 1'b1) >= {1'b0, $past(window_len)}));

    a_r8_initial_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !steady_sel |-> (mu_shift == SHIFT_W'(BASE_SH)));

    a_r8_fine_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!steady_sel && !$stable(fine_shift)) |-> (mu_shift == SHIFT_W'(BASE_SH)));

    a_r2_prime_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_PRIME) |-> ((run_count == '0) && !steady_sel));

endmodule

bind scc_top scc_checker #(
    .CNT_W   (CNT_W),
    .P_W     (P_W),
    .SHIFT_W (SHIFT_W),
    .BASE_SH (BASE_SH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_valid  (err_valid),
    .err_sign   (err_sign),
    .window_len (window_len),
    .fine_shift (fine_shift),
    .steady_sel (steady_sel),
    .mu_shift   (mu_shift),
    .run_count  (run_count),
    .prev_sign  (prev_sign),
    .phase      (phase)
);

// File: tb/tb_scc_top.sv
module tb_scc_top;

    localparam int CNT_W = 16;
    localparam int P_W   = 4;
    localparam int SW    = 5;
    localparam int BASE  = 4;

    typedef struct packed {
        logic          v;
        logic          s;
        logic [15:0]   w;
        logic [3:0]    f;
        logic          exp_st;
        logic [4:0]    exp_sh;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 16'd3, 4'd3, 1'b0, 5'd4},
        '{1'b1, 1'b0, 16'd3, 4'd3, 1'b0, 5'd4},
        '{1'b1, 1'b1, 16'd3, 4'd3, 1'b0, 5'd4},
        '{1'b1, 1'b1, 16'd3, 4'd3, 1'b0, 5'd4},
        '{1'b0, 1'b0, 16'd3, 4'd3, 1'b0, 5'd4},
        '{1'b1, 1'b1, 16'd3, 4'd3, 1'b0, 5'd4},
        '{1'b1, 1'b1, 16'd3, 4'd3, 1'b1, 5'd7},
        '{1'b1, 1'b0, 16'd3, 4'd3, 1'b1, 5'd7},
        '{1'b0, 1'b1, 16'd3, 4'd5, 1'b1, 5'd9}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             err_valid = 1'b0;
    logic             err_sign = 1'b0;
    logic [CNT_W-1:0] window_len = '0;
    logic [P_W-1:0]   fine_shift = '0;
    logic             steady_sel;
    logic [SW-1:0]    mu_shift;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    scc_top #(.FILT_ORDER(16), .CNT_W(CNT_W), .P_W(P_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_valid  (err_valid),
        .err_sign   (err_sign),
        .window_len (window_len),
        .fine_shift (fine_shift),
        .steady_sel (steady_sel),
        .mu_shift   (mu_shift)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic s);
        err_valid = v;
        err_sign  = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        err_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 steady in reset", int'(steady_sel), 0);
        chk("R1 shift in reset", int'(mu_shift), BASE);
        do_reset();
        chk("R1 steady after reset", int'(steady_sel), 0);
        chk("R1 shift after reset", int'(mu_shift), BASE);

        // table: R3 run growth, R4 break, R7 idle with opposite sign, R6 sticky, R8 shift
        for (int i = 0; i < NV; i++) begin
            window_len = TBL[i].w;
            fine_shift = TBL[i].f;
            step(TBL[i].v, TBL[i].s);
            chk($sformatf("R3/R4/R7 vec %0d steady", i), int'(steady_sel), int'(TBL[i].exp_st));
            chk($sformatf("R6/R8 vec %0d shift", i), int'(mu_shift), int'(TBL[i].exp_sh));
        end

        // R8: fine_shift follows combinationally in steady phase
        fine_shift = 4'd15;
        #1;
        chk("R8 steady follows fine_shift", int'(mu_shift), BASE + 15);

        // R6: sticky across many changes
        window_len = 16'd60000;
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk("R6 stays steady", int'(steady_sel), 1);

        // R2 and R5: window 0
        window_len = '0;
        fine_shift = 4'd2;
        do_reset();
        chk("R1 steady cleared by reset", int'(steady_sel), 0);
        step(1'b1, 1'b1);
        chk("R2 first sample no switch", int'(steady_sel), 0);
        step(1'b1, 1'b1);
        chk("R5 window 0 switches on first pair", int'(steady_sel), 1);
        chk("R8 steady shift", int'(mu_shift), BASE + 2);

        // R8: fine_shift ignored in initial phase; R4 restart count from one
        do_reset();
        window_len = 16'd2;
        fine_shift = 4'd9;
        #1;
        chk("R8 fine ignored initial", int'(mu_shift), BASE);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        chk("R4 run restarted after break", int'(steady_sel), 0);
        step(1'b1, 1'b1);
        chk("R10 switch after completing pair", int'(steady_sel), 1);

        // R9: window lowered mid-run
        do_reset();
        window_len = 16'd10;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk("R9 no switch at run 3 with window 10", int'(steady_sel), 0);
        window_len = 16'd2;
        step(1'b0, 1'b1);
        chk("R7 idle does not switch", int'(steady_sel), 0);
        step(1'b1, 1'b0);
        chk("R9 lowered window switches", int'(steady_sel), 1);

        // R5 window 1 equals window 0 behaviour; R10 not before edge
        do_reset();
        window_len = 16'd1;
        step(1'b1, 1'b0);
        err_valid = 1'b1;
        err_sign  = 1'b0;
        #1;
        chk("R10 no switch before edge", int'(steady_sel), 0);
        step(1'b1, 1'b0);
        chk("R5 window 1 first pair", int'(steady_sel), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule